// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O port, `W` pins wide (12 by default). Software reaches it through a simple synchronous register bus. Writes take effect on the rising clock edge. Reads are combinational from the addressed register. Each pin is either an input or an output. Output values sit in a port register that a per-bit protection mask can shield from software writes. A separate clear register drives selected output pins low.

Every input is resynchronised with two flops before any use. Each pin has its own interrupt detector, and per pin software chooses:

- edge or level sensing;
- one edge or both edges;
- polarity.

Detected edges stay latched until software clears them with a write-one-to-clear register. Level conditions follow the pin. Raw and enabled status are both readable, and any enabled condition raises a single interrupt request.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, and `pin_out`, `pin_oe` and `irq` are all 0. The register offsets are: port data 0x00, direction 0x04, protect 0x08, clear 0x0C, sense select 0x10, both-edge 0x14, polarity 0x18, enable 0x1C, raw status 0x20, enabled status 0x24, status clear 0x28.
- R2: A direction bit of 1 makes that pin an output (`pin_oe` bit 1). A direction bit of 0 makes it an input. `pin_out` always shows the port output register.
- R3: A write to port data changes only the output bits whose protect bit is 0. Bits whose protect bit is 1 keep their old value.
- R4: A write to clear with bit i = 1 drives output bit i to 0, but only if pin i is an output and its protect bit is 0. The write never sets a bit, and clear reads back as 0.
- R5: A read of port data returns the output register bit for output pins and the synchronised pin input for input pins.
- R6: A change on `pin_in` appears in the port data read-back after the second rising clock edge that follows the change, and not after the first.
- R7: When sense select is 0 and both-edge is 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge into raw status. The opposite edge is ignored.
- R8: When sense select is 0 and both-edge is 1, both rising and falling edges latch raw status, whatever the polarity bit holds.
- R9: When sense select is 1, raw status follows the synchronised input: high when polarity is 1, low when polarity is 0. A status-clear write has no effect on it, and no edge is latched while the pin is level sensed.
- R10: Writing 1 to a status-clear bit removes that pin's latched edge. Writing 0 leaves it set. A latched edge never falls without a clear.
- R11: Enabled status equals raw status ANDed with enable. `irq` is 1 exactly when any enabled status bit is 1. An enable bit of 0 leaves raw status untouched.
- R12: Raw and enabled status are read-only, so writes to them are ignored. Status clear is write-only and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address of the register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data of the addressed register |
| pin_in | input | W | Asynchronous pin inputs |
| pin_out | output | W | Output values to the pads |
| pin_oe | output | W | Per-pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The detector is driven with four kinds of input:

- Single rising and falling transitions on pins set for one polarity, which separates the correct edge from the opposite one.
- The same transitions on a both-edge pin, which shows that the polarity bit is overridden.
- Held high and low levels on a level-sensed pin, which shows that status tracks the pin and ignores clears.
- A one-cycle-stepped input change, which pins down the two-flop latency.

The port path uses output patterns that mix input and output pins with and without protection, so a wrong read multiplexer, a mask applied the wrong way round, or a clear that ignores direction each gives a different value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_DIR  = 8'h04;
  localparam logic [7:0] OFS_PROT = 8'h08;
  localparam logic [7:0] OFS_CLR  = 8'h0C;
  localparam logic [7:0] OFS_SENS = 8'h10;
  localparam logic [7:0] OFS_BOTH = 8'h14;
  localparam logic [7:0] OFS_POL  = 8'h18;
  localparam logic [7:0] OFS_EN   = 8'h1C;
  localparam logic [7:0] OFS_RAW  = 8'h20;
  localparam logic [7:0] OFS_ENST = 8'h24;
  localparam logic [7:0] OFS_SCLR = 8'h28;

  // Edge qualification for one pin: both edges, or the one picked by polarity.
  function automatic logic edge_hit(input logic both, input logic pol,
                                    input logic rise, input logic fall);
    return both ? (rise | fall) : (pol ? rise : fall);
  endfunction

  // Level qualification for one pin: active high when pol is 1.
  function automatic logic level_hit(input logic pol, input logic lvl);
    return pol ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic sense_level,
  input  logic both,
  input  logic pol,
  input  logic clr,
  output logic raw,
  output logic edge_evt
);
  logic latch_q;
  logic rise;
  logic fall;

  assign rise     = cur & ~prev;
  assign fall     = ~cur & prev;
  assign edge_evt = ~sense_level & edge_hit(both, pol, rise, fall);

  // A new event wins over a clear that arrives in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (edge_evt) latch_q <= 1'b1;
    else if (clr)      latch_q <= 1'b0;
  end

  assign raw = sense_level ? level_hit(pol, cur) : latch_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W  = 12,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  logic [W-1:0] out_q, dir_q, prot_q, sens_q, both_q, pol_q, en_q;
  logic [W-1:0] sync_cur, sync_prev;
  logic [W-1:0] raw_st, en_st, edge_evt, sclr_bits;
  logic wr_data, wr_dir, wr_prot, wr_clr, wr_sens, wr_both, wr_pol, wr_en, wr_sclr;

  assign wr_data = bus_wr && (bus_addr == OFS_DATA[AW-1:0]);
  assign wr_dir  = bus_wr && (bus_addr == OFS_DIR[AW-1:0]);
  assign wr_prot = bus_wr && (bus_addr == OFS_PROT[AW-1:0]);
  assign wr_clr  = bus_wr && (bus_addr == OFS_CLR[AW-1:0]);
  assign wr_sens = bus_wr && (bus_addr == OFS_SENS[AW-1:0]);
  assign wr_both = bus_wr && (bus_addr == OFS_BOTH[AW-1:0]);
  assign wr_pol  = bus_wr && (bus_addr == OFS_POL[AW-1:0]);
  assign wr_en   = bus_wr && (bus_addr == OFS_EN[AW-1:0]);
  assign wr_sclr = bus_wr && (bus_addr == OFS_SCLR[AW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      prot_q <= '0;
      sens_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      if (wr_data)     out_q <= (out_q & prot_q) | (bus_wdata & ~prot_q);
      else if (wr_clr) out_q <= out_q & ~(bus_wdata & dir_q & ~prot_q);
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_prot) prot_q <= bus_wdata;
      if (wr_sens) sens_q <= bus_wdata;
      if (wr_both) both_q <= bus_wdata;
      if (wr_pol)  pol_q  <= bus_wdata;
      if (wr_en)   en_q   <= bus_wdata;
    end
  end

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .cur(sync_cur), .prev(sync_prev)
  );

  assign sclr_bits = wr_sclr ? bus_wdata : '0;

  for (genvar g = 0; g < W; g++) begin : g_pin
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .cur(sync_cur[g]), .prev(sync_prev[g]),
      .sense_level(sens_q[g]), .both(both_q[g]), .pol(pol_q[g]),
      .clr(sclr_bits[g]), .raw(raw_st[g]), .edge_evt(edge_evt[g])
    );
  end

  assign en_st   = raw_st & en_q;
  assign irq     = |en_st;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA[AW-1:0]: bus_rdata = (dir_q & out_q) | (~dir_q & sync_cur);
      OFS_DIR[AW-1:0]:  bus_rdata = dir_q;
      OFS_PROT[AW-1:0]: bus_rdata = prot_q;
      OFS_SENS[AW-1:0]: bus_rdata = sens_q;
      OFS_BOTH[AW-1:0]: bus_rdata = both_q;
      OFS_POL[AW-1:0]:  bus_rdata = pol_q;
      OFS_EN[AW-1:0]:   bus_rdata = en_q;
      OFS_RAW[AW-1:0]:  bus_rdata = raw_st;
      OFS_ENST[AW-1:0]: bus_rdata = en_st;
      default:          bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_data,
  input logic         wr_clr,
  input logic         wr_sclr,
  input logic [W-1:0] prot_q,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] raw_st,
  input logic [W-1:0] en_q,
  input logic [W-1:0] sens_q,
  input logic [W-1:0] edge_evt,
  input logic         irq
);
  // R3: protected bits do not move on a port data write
  a_r3_prot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (((pin_out ^ $past(pin_out)) & $past(prot_q)) == '0));

  // R4: a clear write never raises an output bit
  a_r4_clr_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & ~$past(pin_out)) == '0));

  // R7: a qualified edge on an edge-sensed pin shows in raw status next cycle
  a_r7_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_evt & ~sens_q) & ~sens_q & ~raw_st) == '0));

  // R10: without a status-clear write, latched edges stay set
  a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sclr |=> (($past(raw_st) & ~raw_st & ~sens_q & ~$past(sens_q)) == '0));

  // R11: the request needs an enabled raw condition
  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_st & en_q) != '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_clr(wr_clr),
  .wr_sclr(wr_sclr), .prot_q(prot_q), .pin_out(pin_out), .raw_st(raw_st),
  .en_q(en_q), .sens_q(sens_q), .edge_evt(edge_evt), .irq(irq)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int W = 12;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_DATA = 6'h00, A_DIR = 6'h04, A_PROT = 6'h08,
    A_CLR = 6'h0C, A_SENS = 6'h10, A_BOTH = 6'h14, A_POL = 6'h18,
    A_EN = 6'h1C, A_RAW = 6'h20, A_ENST = 6'h24, A_SCLR = 6'h28;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pin_in = '0;
  logic [W-1:0] bus_rdata, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_irq_port #(.W(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
    logic [W-1:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic drive_pins(input logic [W-1:0] v);
    @(negedge clk); pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 'h28; a += 4) rd_chk("R1 reg", AW'(a), '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irq", {{(W-1){1'b0}}, irq}, '0);
  endtask

  task automatic t_output;
    wr(A_DIR, 12'h0F0);
    wr(A_DATA, 12'hABC);
    check("R2 pin_oe", pin_oe, 12'h0F0);
    check("R2 pin_out", pin_out, 12'hABC);
    drive_pins(12'h555);
    rd_chk("R5 data mux", A_DATA, 12'h5B5);
  endtask

  task automatic t_protect;
    wr(A_PROT, 12'h00F);
    wr(A_DATA, 12'h000);
    check("R3 protected write", pin_out, 12'h00C);
    rd_chk("R3 protect readback", A_PROT, 12'h00F);
  endtask

  task automatic t_clear;
    wr(A_PROT, 12'h000);
    wr(A_DATA, 12'hFFF);
    wr(A_PROT, 12'h003);
    wr(A_CLR, 12'hFFF);
    check("R4 clear outputs", pin_out, 12'hF0F);
    rd_chk("R4 clear reads 0", A_CLR, '0);
    wr(A_PROT, '0); wr(A_DIR, '0); wr(A_DATA, '0);
    drive_pins('0);
    wr(A_SCLR, 12'hFFF);
  endtask

  task automatic t_sync;
    @(negedge clk); bus_addr = A_DATA; pin_in = 12'h001;
    @(posedge clk); #1 check("R6 after one edge", bus_rdata, 12'h000);
    @(posedge clk); #1 check("R6 after two edges", bus_rdata, 12'h001);
    drive_pins('0);
    rd_chk("R7 falling edge with pol 0", A_RAW, 12'h001);
    wr(A_SCLR, 12'hFFF);
  endtask

  task automatic t_edge;
    wr(A_POL, 12'h001);
    wr(A_EN, 12'hFFF);
    drive_pins(12'h003);
    rd_chk("R7 rising only on pol 1", A_RAW, 12'h001);
    rd_chk("R11 enabled status", A_ENST, 12'h001);
    check("R11 irq set", {{(W-1){1'b0}}, irq}, 12'h001);
    drive_pins('0);
    rd_chk("R7 falling on pol 0", A_RAW, 12'h003);
    wr(A_SCLR, 12'hFFF);
    rd_chk("R10 clear all", A_RAW, '0);
    check("R11 irq clear", {{(W-1){1'b0}}, irq}, '0);
  endtask

  task automatic t_both;
    wr(A_BOTH, 12'h004);
    drive_pins(12'h004);
    rd_chk("R8 rise on both", A_RAW, 12'h004);
    wr(A_SCLR, 12'h004);
    rd_chk("R10 clear one", A_RAW, '0);
    drive_pins('0);
    rd_chk("R8 fall on both", A_RAW, 12'h004);
    wr(A_SCLR, 12'h000);
    rd_chk("R10 zero write keeps", A_RAW, 12'h004);
    wr(A_SCLR, 12'h004);
    rd_chk("R10 clear again", A_RAW, '0);
  endtask

  task automatic t_level;
    wr(A_POL, 12'h009);
    wr(A_SENS, 12'h008);
    rd_chk("R9 high level idle", A_RAW, '0);
    drive_pins(12'h008);
    rd_chk("R9 high level active", A_RAW, 12'h008);
    wr(A_SCLR, 12'h008);
    rd_chk("R9 clear ignored", A_RAW, 12'h008);
    drive_pins('0);
    rd_chk("R9 follows input", A_RAW, '0);
    wr(A_POL, 12'h001);
    rd_chk("R9 low level active", A_RAW, 12'h008);
    wr(A_POL, 12'h009);
    rd_chk("R9 no edge latched", A_RAW, '0);
  endtask

  task automatic t_enable;
    drive_pins(12'h001);
    wr(A_EN, 12'h000);
    rd_chk("R11 raw kept", A_RAW, 12'h001);
    rd_chk("R11 masked", A_ENST, '0);
    check("R11 irq masked", {{(W-1){1'b0}}, irq}, '0);
    wr(A_EN, 12'h001);
    check("R11 irq back", {{(W-1){1'b0}}, irq}, 12'h001);
    wr(A_RAW, 12'h000);
    wr(A_ENST, 12'h000);
    rd_chk("R12 raw read-only", A_RAW, 12'h001);
    rd_chk("R12 status clear reads 0", A_SCLR, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_output;
    t_protect;
    t_clear;
    t_sync;
    t_edge;
    t_both;
    t_level;
    t_enable;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule